// File: doc/BRIEF.md
# Configurable AND-OR Array Logic

This block is a small sum-of-products logic device whose function is set by a configuration image. Dedicated input pins and the sensed levels of bidirectional pins form the array inputs. Each array input gives two literal lines, one true and one complemented. Every product term is a programmable AND across those literal lines. The OR plane is hard-wired: each output cell sums its own fixed group of product terms. The sum then passes through a per-cell inversion choice and a per-cell drive enable.

The image is loaded serially before use. While the load strobe is high, one bit enters on each clock edge, first bit first. When the strobe falls after exactly the right number of bits, the array goes live. Until then every pin driver stays off. The whole logic path from the pins to the outputs is combinational. The only state is the configuration image and the live flag.

Top module: `pal_array`

## Requirements
- R1: After reset, every `pinOe` bit is 0 and every `pinOut` bit is 0.
- R2: The image is shifted in MSB first, one bit per clock edge while `progEn` is high. The array goes live only when `progEn` falls after exactly CFG_BITS shifted bits, where CFG_BITS = 2·(NUM_DED+NUM_IO)·NUM_OUT·TERMS_PER_OUT + 2·NUM_OUT. After any other count, all drivers stay off.
- R3: From the first clock edge that sees `progEn` high, all `pinOe` bits are 0 until the next successful load completes.
- R4: Image bit t·NUM_LIT + l connects literal l to product term t, where NUM_LIT = 2·(NUM_DED+NUM_IO). For array input k, literal 2k is the true copy and literal 2k+1 is the complement. A term is the AND of its connected literals, and an unconnected literal has no effect on the term.
- R5: A product term with no connected literal is 1. A term with both copies of one array input connected is 0.
- R6: Output cell c is the OR of product terms c·TERMS_PER_OUT through c·TERMS_PER_OUT+TERMS_PER_OUT−1.
- R7: Image bit FUSE_BITS+2c inverts cell c's OR result when it is 1, where FUSE_BITS = NUM_LIT·NUM_OUT·TERMS_PER_OUT.
- R8: Image bit FUSE_BITS+2c+1 enables cell c's driver. A cell that is disabled, or not yet live, shows `pinOe`=0 and `pinOut`=0.
- R9: Array inputs 0..NUM_DED−1 are `dedIn`. Array input NUM_DED+i is the sensed pin level `pinIn[i]` of bidirectional cell i, and it feeds back whether or not that cell's driver is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration load |
| rstN | input | 1 | Active-low synchronous reset |
| progEn | input | 1 | Load strobe; high while image bits shift in |
| progData | input | 1 | Serial image bit |
| dedIn | input | NUM_DED | Dedicated array inputs |
| pinIn | input | NUM_IO | Sensed levels of the bidirectional pins (cells 0..NUM_IO−1) |
| pinOut | output | NUM_OUT | Value driven by each output cell |
| pinOe | output | NUM_OUT | Driver enable for each output cell |

## Verification
The bench uses the default parameters: 10 dedicated inputs, 6 bidirectional cells, 8 output cells and 7 terms per cell, which gives a 1808-bit image. With these values, one image can exercise at the same time:
- the two-input exclusive-OR and its inverse,
- empty terms and self-cancelling terms,
- feedback through both literal copies,
- a disabled cell,
- a cell with no feedback pin.

Loads that are one bit short, and a reload over a live image, exercise the commit and the tristate-during-load behaviour.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  // Strobes from the load controller to the array datapath
  typedef struct packed {
    logic shift;   // shift one image bit in
    logic drop;    // leave the live state
    logic commit;  // enter the live state
  } palStrobe_t;
endpackage

// File: rtl/pal_ctrl.sv
`timescale 1ns/1ps
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int CFG_BITS = 1808
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       progEn,
  output palStrobe_t strb
);
  localparam int CW = $clog2(CFG_BITS + 2);
  localparam logic [CW-1:0] FULL = CW'(CFG_BITS);
  localparam logic [CW-1:0] OVER = CW'(CFG_BITS + 1);

  logic [CW-1:0] shiftCnt;
  logic          progEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftCnt <= '0;
      progEnQ  <= 1'b0;
    end else begin
      progEnQ <= progEn;
      if (progEn) begin
        if (shiftCnt != OVER) shiftCnt <= shiftCnt + CW'(1);
      end else begin
        shiftCnt <= '0;
      end
    end
  end

  always_comb begin
    strb.shift  = progEn;
    strb.drop   = progEn;
    strb.commit = !progEn && progEnQ && (shiftCnt == FULL);
  end
endmodule

// File: rtl/pal_out_cell.sv
`timescale 1ns/1ps
module pal_out_cell #(
  parameter int TERMS = 7
) (
  input  logic [TERMS-1:0] terms,
  input  logic             invBit,
  input  logic             enBit,
  input  logic             live,
  output logic             cellOut,
  output logic             cellOe
);
  logic sumVal;
  logic polVal;

  always_comb begin
    sumVal  = |terms;
    polVal  = sumVal ^ invBit;
    cellOe  = live & enBit;
    cellOut = cellOe & polVal;
  end
endmodule

// File: rtl/pal_datapath.sv
`timescale 1ns/1ps
module pal_datapath
  import pal_pkg::*;
#(
  parameter int NUM_DED       = 10,
  parameter int NUM_IO        = 6,
  parameter int NUM_OUT       = 8,
  parameter int TERMS_PER_OUT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  palStrobe_t         strb,
  input  logic               progData,
  input  logic [NUM_DED-1:0] dedIn,
  input  logic [NUM_IO-1:0]  pinIn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic [NUM_OUT-1:0] pinOe
);
  localparam int NUM_ARR   = NUM_DED + NUM_IO;
  localparam int NUM_LIT   = 2 * NUM_ARR;
  localparam int NUM_TERMS = NUM_OUT * TERMS_PER_OUT;
  localparam int FUSE_BITS = NUM_TERMS * NUM_LIT;
  localparam int CFG_BITS  = FUSE_BITS + 2 * NUM_OUT;

  logic [CFG_BITS-1:0]  cfgBits;
  logic                 live;
  logic [NUM_ARR-1:0]   arrIn;
  logic [NUM_LIT-1:0]   lits;
  logic [NUM_TERMS-1:0] termVal;

  // Image shift chain and live flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBits <= '0;
      live    <= 1'b0;
    end else begin
      if (strb.shift) cfgBits <= {cfgBits[CFG_BITS-2:0], progData};
      if (strb.drop)        live <= 1'b0;
      else if (strb.commit) live <= 1'b1;
    end
  end

  assign arrIn = {pinIn, dedIn};

  // True and complemented literal lines
  for (genvar k = 0; k < NUM_ARR; k++) begin : g_lit
    assign lits[2*k]   = arrIn[k];
    assign lits[2*k+1] = ~arrIn[k];
  end

  // Programmable AND plane: an unset bit masks its literal to 1
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    assign termVal[t] = &(~cfgBits[t*NUM_LIT +: NUM_LIT] | lits);
  end

  // Fixed OR plane and output cells
  for (genvar c = 0; c < NUM_OUT; c++) begin : g_cell
    pal_out_cell #(.TERMS(TERMS_PER_OUT)) u_cell (
      .terms  (termVal[c*TERMS_PER_OUT +: TERMS_PER_OUT]),
      .invBit (cfgBits[FUSE_BITS + 2*c]),
      .enBit  (cfgBits[FUSE_BITS + 2*c + 1]),
      .live   (live),
      .cellOut(pinOut[c]),
      .cellOe (pinOe[c])
    );
  end
endmodule

// File: rtl/pal_array.sv
`timescale 1ns/1ps
module pal_array
  import pal_pkg::*;
#(
  parameter int NUM_DED       = 10,
  parameter int NUM_IO        = 6,
  parameter int NUM_OUT       = 8,
  parameter int TERMS_PER_OUT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               progEn,
  input  logic               progData,
  input  logic [NUM_DED-1:0] dedIn,
  input  logic [NUM_IO-1:0]  pinIn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic [NUM_OUT-1:0] pinOe
);
  localparam int NUM_LIT  = 2 * (NUM_DED + NUM_IO);
  localparam int CFG_BITS = NUM_LIT * NUM_OUT * TERMS_PER_OUT + 2 * NUM_OUT;

  palStrobe_t strb;

  pal_ctrl #(.CFG_BITS(CFG_BITS)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .progEn(progEn),
    .strb  (strb)
  );

  pal_datapath #(
    .NUM_DED      (NUM_DED),
    .NUM_IO       (NUM_IO),
    .NUM_OUT      (NUM_OUT),
    .TERMS_PER_OUT(TERMS_PER_OUT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .progData(progData),
    .dedIn   (dedIn),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );
endmodule

// File: rtl/pal_array_chk.sv
`timescale 1ns/1ps
module pal_array_chk #(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               progEn,
  input logic [NUM_OUT-1:0] pinOut,
  input logic [NUM_OUT-1:0] pinOe
);
  // R1: drivers off on the first cycle out of reset
  a_r1_reset_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0));

  // R3: a load in progress keeps every driver off
  a_r3_load_tristate: assert property (@(posedge clk) disable iff (!rstN)
    progEn |=> (pinOe == '0));

  // R2: drivers can only turn on right after the load strobe falls
  a_r2_commit_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|pinOe) |-> (!$past(progEn) && $past(progEn, 2)));

  // R8: a cell that is not driving shows a low value
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut & ~pinOe) == '0));
endmodule

bind pal_array pal_array_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .progEn(progEn),
  .pinOut(pinOut),
  .pinOe (pinOe)
);

// File: tb/pal_array_bench.sv
`timescale 1ns/1ps
module pal_array_bench;
  localparam int ND = 10;
  localparam int NI = 6;
  localparam int NO = 8;
  localparam int TP = 7;
  localparam int NL = 2 * (ND + NI);
  localparam int FB = NL * NO * TP;
  localparam int CB = FB + 2 * NO;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          progEn = 1'b0;
  logic          progData = 1'b0;
  logic [ND-1:0] dedIn = '0;
  logic [NI-1:0] pinIn = '0;
  logic [NO-1:0] pinOut;
  logic [NO-1:0] pinOe;

  int nCmp = 0;
  int nBad = 0;

  logic [CB-1:0] cfg;
  logic          cfgLive = 1'b0;

  typedef struct {
    logic [NO-1:0] expOut;
    logic [NO-1:0] expOe;
  } item_t;
  item_t scq[$];
  event  chkEv;

  always #4 clk = ~clk;

  pal_array #(.NUM_DED(ND), .NUM_IO(NI), .NUM_OUT(NO), .TERMS_PER_OUT(TP)) u_pal_array (
    .clk(clk), .rstN(rstN), .progEn(progEn), .progData(progData),
    .dedIn(dedIn), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic string cellTag(input int c);
    case (c)
      0: return "R4 xor cell";
      1: return "R5 empty term";
      2: return "R7/R9 inverted feedback";
      3: return "R8 enable";
      4: return "R5 cancelled terms";
      5: return "R9 complement feedback";
      6: return "R6 fixed OR group";
      default: return "R4 three-literal AND";
    endcase
  endfunction

  // Reference model written from the requirements
  task automatic model(input logic [ND-1:0] d, input logic [NI-1:0] p,
                       output logic [NO-1:0] o, output logic [NO-1:0] e);
    logic [NL-1:0] lit;
    for (int k = 0; k < ND + NI; k++) begin
      logic v;
      if (k < ND) v = d[k];
      else        v = p[k-ND];
      lit[2*k]   = v;
      lit[2*k+1] = ~v;
    end
    for (int c = 0; c < NO; c++) begin
      logic sum;
      sum = 1'b0;
      for (int j = 0; j < TP; j++) begin
        logic term;
        term = 1'b1;
        for (int l = 0; l < NL; l++)
          if (cfg[(c*TP+j)*NL + l] && !lit[l]) term = 1'b0;
        sum = sum | term;
      end
      e[c] = cfgLive & cfg[FB + 2*c + 1];
      o[c] = e[c] & (sum ^ cfg[FB + 2*c]);
    end
  endtask

  task automatic clrTerm(input int t);
    cfg[t*NL +: NL] = '0;
  endtask
  task automatic conn(input int t, input int l);
    cfg[t*NL + l] = 1'b1;
  endtask

  task automatic buildImage(input logic xnorMode);
    cfg = '0;
    cfg[FB-1:0] = '1;                          // every term cancelled
    clrTerm(0);  conn(0, 0);  conn(0, 3);      // in0 & ~in1
    clrTerm(1);  conn(1, 1);  conn(1, 2);      // ~in0 & in1
    cfg[FB+0] = xnorMode; cfg[FB+1] = 1'b1;
    clrTerm(7);  cfg[FB+3] = 1'b1;             // empty term -> 1
    clrTerm(14); conn(14, 2*ND);               // pinIn[0]
    cfg[FB+4] = 1'b1; cfg[FB+5] = 1'b1;
    clrTerm(21); cfg[FB+7] = xnorMode;         // enabled only in second image
    cfg[FB+9] = 1'b1;                          // all terms cancelled
    clrTerm(35); conn(35, 2*(ND+5)+1); conn(35, 4);
    cfg[FB+11] = 1'b1;
    clrTerm(42); conn(42, 6);
    clrTerm(48); conn(48, 8);
    cfg[FB+13] = 1'b1;
    clrTerm(49); conn(49, 10); conn(49, 12); conn(49, 15);
    cfg[FB+14] = 1'b1; cfg[FB+15] = 1'b1;
  endtask

  task automatic loadImage(input int nBits, input logic midCheck);
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk);
      progEn   = 1'b1;
      progData = cfg[CB-1-i];
      if (midCheck && i == 6) begin
        nCmp++;
        if (pinOe !== '0) begin
          nBad++;
          $display("FAIL R3 drivers during load: actual %b expected %b", pinOe, {NO{1'b0}});
        end
      end
    end
    @(negedge clk);
    progEn = 1'b0;
    @(negedge clk);
    cfgLive = (nBits == CB);
  endtask

  task automatic drive(input logic [ND-1:0] d, input logic [NI-1:0] p);
    item_t it;
    @(negedge clk);
    dedIn = d;
    pinIn = p;
    model(d, p, it.expOut, it.expOe);
    scq.push_back(it);
    #2;
    ->chkEv;
    #1;
  endtask

  task automatic sweep(input int n);
    for (int v = 0; v < n; v++) begin
      logic [ND-1:0] d;
      logic [NI-1:0] p;
      d = ND'($urandom);
      p = NI'($urandom);
      d[1:0] = v[1:0];
      p[0] = v[2];
      drive(d, p);
    end
  endtask

  // Monitor: pops expectations and compares with the pins
  initial begin
    forever begin
      item_t it;
      @(chkEv);
      it = scq.pop_front();
      for (int c = 0; c < NO; c++) begin
        nCmp++;
        if (pinOut[c] !== it.expOut[c] || pinOe[c] !== it.expOe[c]) begin
          nBad++;
          $display("FAIL %s cell %0d: actual out=%b oe=%b expected out=%b oe=%b",
                   (cfgLive ? cellTag(c) : "R1/R2 not live"), c,
                   pinOut[c], pinOe[c], it.expOut[c], it.expOe[c]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    cfg = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, nothing live
    sweep(4);
    // R2: a load one bit short leaves drivers off
    buildImage(1'b0);
    loadImage(CB - 1, 1'b0);
    sweep(4);
    // First image: xor, feedback, fixed OR groups
    loadImage(CB, 1'b0);
    sweep(40);
    // R3: reload over a live image, mid-load check, then xnor image
    buildImage(1'b1);
    loadImage(CB, 1'b1);
    sweep(24);
    #20;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule